// File: doc/BRIEF.md
# Auto-increment transfer data buffer

This block is the staging memory between a register-mapped software port and the byte-wide port of a serial flash sequencer. It stores 512 bytes as 128 words of 32 bits. Software sets a direction bit, an auto-advance bit and a word address in a control register. It then moves whole words through one data register. When auto-advance is on, the word address steps forward by one after every accepted data access and wraps from the last word back to word 0.

The sequencer side has its own byte pointer. A begin pulse loads that pointer from a separate start-word register and selects either the outgoing or the incoming direction. Outgoing bytes are presented in little-endian order within each word. Incoming bytes are collected in an assembly register and committed as a word when the top lane arrives. A word left unfinished at the end pulse is written during one flush cycle, and only the lanes actually received are updated.

The sequencer is a four-state machine:
- SQ_IDLE goes to SQ_OUT or SQ_IN on a begin pulse, chosen by the direction input.
- SQ_OUT returns to SQ_IDLE on an end pulse.
- SQ_IN goes to SQ_FLUSH on an end pulse if bytes are still pending, and otherwise to SQ_IDLE.
- SQ_FLUSH always returns to SQ_IDLE.
- A begin pulse restarts the machine from any state.

Top module: `xfer_buf`

## Requirements
- R1: After reset the control register reads 0 (software-read direction, auto-advance off, word address 0), the start-word register reads 0, `seq_busy` is 0 and `seq_rdata` is 0.
- R2: A data-register write (`reg_sel`=1) with the direction bit (control bit 31) set stores the full word at the current word address. With auto-advance (control bit 30) set, the address then rises by one; with it clear, the address holds.
- R3: A data-register read with the direction bit clear returns, in the same cycle as `reg_rd`, the word at the current word address. With auto-advance set, the address then rises by one; with it clear, the address holds.
- R4: The software word address wraps from 127 to 0 on an auto-advancing access.
- R5: A data access against the selected direction is ignored. A write while bit 31 is 0 stores nothing and does not move the address. A read while bit 31 is 1 returns 0 and does not move the address.
- R6: A control write (`reg_sel`=0) loads bit 31, bit 30 and the word address from bits [7:0] modulo 128. A control read returns {bit31, bit30, zeros, current word address}. A write to `reg_sel`=2 sets the start word from bits [7:0] modulo 128 and reads back the same way.
- R7: A `seq_begin` pulse loads the byte pointer with the start word times 4 and raises `seq_busy` from the next cycle. It enters the incoming direction when `seq_in`=1 and the outgoing direction otherwise.
- R8: In the outgoing direction, `seq_rdata` shows the byte at the byte pointer, lane 0 first within each word. Each `seq_rd_en` cycle advances the pointer, which wraps from byte 511 to byte 0.
- R9: In the incoming direction, each `seq_wr_en` byte goes into lane (pointer mod 4). The byte in lane 3 commits the assembled word to the buffer at that clock edge.
- R10: A `seq_end` with uncommitted incoming bytes enters a one-cycle flush (`seq_busy` still 1) that writes only the received lanes and leaves the other lanes of that word unchanged. The machine then goes idle.
- R11: A control write discards all uncommitted incoming bytes, including a byte arriving in the same cycle. The byte pointer still advances for that byte.
- R12: A `seq_end` with nothing pending returns to idle at once, so `seq_busy` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 start word, 3 unused |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while `reg_rd` is high |
| seq_begin | input | 1 | Start a sequencer pass at the start word |
| seq_in | input | 1 | Pass direction at begin: 1 incoming, 0 outgoing |
| seq_end | input | 1 | End the sequencer pass |
| seq_rd_en | input | 1 | Consume the outgoing byte |
| seq_wr_en | input | 1 | Deliver an incoming byte |
| seq_wdata | input | 8 | Incoming byte |
| seq_rdata | output | 8 | Outgoing byte at the byte pointer |
| seq_busy | output | 1 | Sequencer pass in progress (including flush) |

## Verification
The control-register write and the arrival of an incoming byte can land in the same clock cycle. The write's partial-word reset then competes with the lane update of the assembly register. The bench provokes this by presenting two incoming bytes, then driving a control write and a third byte together in one cycle, then a lane-3 byte. It judges the outcome by reading the word back through the data register: only lane 3 must have changed. The bytes that follow must flush into the next word at the lanes given by the still-advancing pointer.

// File: rtl/xfer_buf_pkg.sv
package xfer_buf_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_START = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_OUT   = 2'd1,
        SQ_IN    = 2'd2,
        SQ_FLUSH = 2'd3
    } seq_state_e;

    localparam int CTRL_DIR_BIT  = 31;
    localparam int CTRL_AUTO_BIT = 30;
    localparam int ADDR_FIELD_W  = 8;

endpackage

// File: rtl/xfer_buf_mem.sv
module xfer_buf_mem #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 128,
    parameter int WA_W   = 7
) (
    input  logic                   clk,
    input  logic                   a_we,
    input  logic [WA_W-1:0]        a_addr,
    input  logic [DATA_W-1:0]      a_wdata,
    output logic [DATA_W-1:0]      a_rword,
    input  logic                   b_we,
    input  logic [DATA_W/8-1:0]    b_be,
    input  logic [WA_W-1:0]        b_addr,
    input  logic [DATA_W-1:0]      b_wdata,
    output logic [DATA_W-1:0]      b_rword
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] store [WORDS];

    // Software port has priority per lane; both ports never write together in use.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (a_we) begin
                store[a_addr][l*8 +: 8] <= a_wdata[l*8 +: 8];
            end else if (b_we && b_be[l]) begin
                store[b_addr][l*8 +: 8] <= b_wdata[l*8 +: 8];
            end
        end
    end

    assign a_rword = store[a_addr];
    assign b_rword = store[b_addr];

endmodule

// File: rtl/xfer_buf_regs.sv
module xfer_buf_regs
    import xfer_buf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WA_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [DATA_W-1:0]  mem_rword,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [WA_W-1:0]    waddr,
    output logic [WA_W-1:0]    start_word,
    output logic               ctrl_clr,
    output logic               ctrl_dir,
    output logic               ctrl_auto
);
    logic sel_ctrl_wr;
    logic sel_start_wr;
    logic data_wr_ok;
    logic data_rd_ok;
    logic advance;

    always_comb begin
        sel_ctrl_wr  = 1'b0;
        sel_start_wr = 1'b0;
        data_wr_ok   = 1'b0;
        data_rd_ok   = 1'b0;
        unique case (reg_sel_e'(reg_sel))
            SEL_CTRL:  sel_ctrl_wr  = reg_wr;
            SEL_DATA: begin
                data_wr_ok = reg_wr &&  ctrl_dir;
                data_rd_ok = reg_rd && !ctrl_dir;
            end
            SEL_START: sel_start_wr = reg_wr;
            SEL_NONE:  ;
        endcase
    end

    assign advance  = (data_wr_ok || data_rd_ok) && ctrl_auto;
    assign ctrl_clr = sel_ctrl_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_dir   <= 1'b0;
            ctrl_auto  <= 1'b0;
            waddr      <= '0;
            start_word <= '0;
        end else begin
            if (sel_ctrl_wr) begin
                ctrl_dir  <= reg_wdata[CTRL_DIR_BIT];
                ctrl_auto <= reg_wdata[CTRL_AUTO_BIT];
                waddr     <= reg_wdata[WA_W-1:0];
            end else if (advance) begin
                waddr <= waddr + 1'b1;
            end
            if (sel_start_wr) begin
                start_word <= reg_wdata[WA_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_CTRL: begin
                    reg_rdata[CTRL_DIR_BIT]  = ctrl_dir;
                    reg_rdata[CTRL_AUTO_BIT] = ctrl_auto;
                    reg_rdata[WA_W-1:0]      = waddr;
                end
                SEL_DATA:  reg_rdata = ctrl_dir ? '0 : mem_rword;
                SEL_START: reg_rdata[WA_W-1:0] = start_word;
                SEL_NONE:  reg_rdata = '0;
            endcase
        end
    end

    assign mem_we    = data_wr_ok;
    assign mem_wdata = reg_wdata;

endmodule

// File: rtl/xfer_buf_seq.sv
module xfer_buf_seq
    import xfer_buf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WA_W   = 7,
    parameter int BA_W   = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   seq_begin,
    input  logic                   seq_in,
    input  logic                   seq_end,
    input  logic                   seq_rd_en,
    input  logic                   seq_wr_en,
    input  logic [7:0]             seq_wdata,
    input  logic                   ctrl_clr,
    input  logic [WA_W-1:0]        start_word,
    input  logic [DATA_W-1:0]      mem_rword,
    output logic [7:0]             seq_rdata,
    output logic                   seq_busy,
    output logic                   wr_we,
    output logic [DATA_W/8-1:0]    wr_be,
    output logic [DATA_W-1:0]      wr_data,
    output logic [WA_W-1:0]        word_addr,
    output seq_state_e             state,
    output logic [BA_W-1:0]        ptr,
    output logic [DATA_W/8-1:0]    pend
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int LAST   = LANES - 1;

    seq_state_e        nxt;
    logic [DATA_W-1:0] asm_data;
    logic [DATA_W-1:0] merged;
    logic [7:0]        rbytes [LANES];
    logic [LANE_W-1:0] lane;
    logic              in_byte;
    logic              out_byte;
    logic              last_lane;
    logic              pend_live;

    assign lane      = ptr[LANE_W-1:0];
    assign word_addr = ptr[BA_W-1:LANE_W];
    assign last_lane = (lane == LANE_W'(LAST));
    assign in_byte   = (state == SQ_IN)  && seq_wr_en && !seq_begin && !seq_end;
    assign out_byte  = (state == SQ_OUT) && seq_rd_en && !seq_begin && !seq_end;
    assign pend_live = (|pend) && !ctrl_clr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rbytes[g] = mem_rword[g*8 +: 8];
        assign merged[g*8 +: 8] = (in_byte && (lane == LANE_W'(g))) ? seq_wdata
                                                                     : asm_data[g*8 +: 8];
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (seq_begin) begin
            nxt = seq_in ? SQ_IN : SQ_OUT;
        end else begin
            unique case (state)
                SQ_IDLE:  nxt = SQ_IDLE;
                SQ_OUT:   if (seq_end) nxt = SQ_IDLE;
                SQ_IN:    if (seq_end) nxt = pend_live ? SQ_FLUSH : SQ_IDLE;
                SQ_FLUSH: nxt = SQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Byte pointer and assembly register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            pend     <= '0;
            asm_data <= '0;
        end else if (seq_begin) begin
            ptr  <= {start_word, {LANE_W{1'b0}}};
            pend <= '0;
        end else begin
            if (in_byte || out_byte) begin
                ptr <= ptr + 1'b1;
            end
            if (ctrl_clr || (state == SQ_FLUSH)) begin
                pend <= '0;
            end else if (in_byte) begin
                if (last_lane) begin
                    pend <= '0;
                end else begin
                    pend[lane] <= 1'b1;
                    asm_data   <= merged;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        wr_we     = 1'b0;
        wr_be     = '0;
        wr_data   = merged;
        seq_rdata = 8'h00;
        unique case (state)
            SQ_IDLE: ;
            SQ_OUT:  seq_rdata = rbytes[lane];
            SQ_IN: begin
                if (in_byte && last_lane && !ctrl_clr) begin
                    wr_we = 1'b1;
                    wr_be = pend | (LANES'(1) << LAST);
                end
            end
            SQ_FLUSH: begin
                if (!ctrl_clr && !seq_begin) begin
                    wr_we = |pend;
                    wr_be = pend;
                end
            end
        endcase
    end

    assign seq_busy = (state != SQ_IDLE);

endmodule

// File: rtl/xfer_buf.sv
module xfer_buf
    import xfer_buf_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              seq_begin,
    input  logic              seq_in,
    input  logic              seq_end,
    input  logic              seq_rd_en,
    input  logic              seq_wr_en,
    input  logic [7:0]        seq_wdata,
    output logic [7:0]        seq_rdata,
    output logic              seq_busy
);
    localparam int LANES = DATA_W / 8;
    localparam int WORDS = BUF_BYTES / LANES;
    localparam int WA_W  = $clog2(WORDS);
    localparam int BA_W  = $clog2(BUF_BYTES);

    logic              sw_we;
    logic [DATA_W-1:0] sw_wdata;
    logic [DATA_W-1:0] sw_rword;
    logic [WA_W-1:0]   sw_waddr;
    logic [WA_W-1:0]   start_word;
    logic              ctrl_clr;
    logic              ctrl_dir;
    logic              ctrl_auto;

    logic              sq_we;
    logic [LANES-1:0]  sq_be;
    logic [DATA_W-1:0] sq_wdata;
    logic [DATA_W-1:0] sq_rword;
    logic [WA_W-1:0]   sq_word;
    seq_state_e        sq_state;
    logic [BA_W-1:0]   sq_ptr;
    logic [LANES-1:0]  sq_pend;

    xfer_buf_regs #(.DATA_W(DATA_W), .WA_W(WA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mem_rword  (sw_rword),
        .mem_we     (sw_we),
        .mem_wdata  (sw_wdata),
        .waddr      (sw_waddr),
        .start_word (start_word),
        .ctrl_clr   (ctrl_clr),
        .ctrl_dir   (ctrl_dir),
        .ctrl_auto  (ctrl_auto)
    );

    xfer_buf_seq #(.DATA_W(DATA_W), .WA_W(WA_W), .BA_W(BA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_begin  (seq_begin),
        .seq_in     (seq_in),
        .seq_end    (seq_end),
        .seq_rd_en  (seq_rd_en),
        .seq_wr_en  (seq_wr_en),
        .seq_wdata  (seq_wdata),
        .ctrl_clr   (ctrl_clr),
        .start_word (start_word),
        .mem_rword  (sq_rword),
        .seq_rdata  (seq_rdata),
        .seq_busy   (seq_busy),
        .wr_we      (sq_we),
        .wr_be      (sq_be),
        .wr_data    (sq_wdata),
        .word_addr  (sq_word),
        .state      (sq_state),
        .ptr        (sq_ptr),
        .pend       (sq_pend)
    );

    xfer_buf_mem #(.DATA_W(DATA_W), .WORDS(WORDS), .WA_W(WA_W)) u_mem (
        .clk     (clk),
        .a_we    (sw_we),
        .a_addr  (sw_waddr),
        .a_wdata (sw_wdata),
        .a_rword (sw_rword),
        .b_we    (sq_we),
        .b_be    (sq_be),
        .b_addr  (sq_word),
        .b_wdata (sq_wdata),
        .b_rword (sq_rword)
    );

endmodule

// File: rtl/xfer_buf_chk.sv
module xfer_buf_chk
    import xfer_buf_pkg::*;
#(
    parameter int WA_W  = 7,
    parameter int BA_W  = 9,
    parameter int LANES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              ctrl_dir,
    input logic              ctrl_auto,
    input logic [WA_W-1:0]   sw_waddr,
    input logic              seq_begin,
    input logic              seq_end,
    input logic              seq_rd_en,
    input logic              seq_busy,
    input seq_state_e        sq_state,
    input logic [BA_W-1:0]   sq_ptr,
    input logic [LANES-1:0]  sq_pend
);
    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_DATA && ctrl_dir && ctrl_auto)
        |=> sw_waddr == WA_W'($past(sw_waddr) + 1'b1)); // R2

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_DATA && !ctrl_dir && ctrl_auto && (&sw_waddr))
        |=> sw_waddr == '0); // R4

    AST_WRONG_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_DATA && !ctrl_dir) |=> $stable(sw_waddr)); // R5

    AST_BEGIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_begin |=> seq_busy); // R7

    AST_OUT_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_state == SQ_OUT && seq_rd_en && !seq_begin && !seq_end)
        |=> sq_ptr == BA_W'($past(sq_ptr) + 1'b1)); // R8

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_state == SQ_FLUSH && !seq_begin) |=> sq_state == SQ_IDLE); // R10

    AST_CTRL_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CTRL) |=> sq_pend == '0); // R11

    AST_END_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && !seq_begin && sq_pend == '0) |=> !seq_busy); // R12

endmodule

bind xfer_buf xfer_buf_chk #(.WA_W(WA_W), .BA_W(BA_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .ctrl_dir  (ctrl_dir),
    .ctrl_auto (ctrl_auto),
    .sw_waddr  (sw_waddr),
    .seq_begin (seq_begin),
    .seq_end   (seq_end),
    .seq_rd_en (seq_rd_en),
    .seq_busy  (seq_busy),
    .sq_state  (sq_state),
    .sq_ptr    (sq_ptr),
    .sq_pend   (sq_pend)
);

// File: tb/xfer_buf_tb.sv
module xfer_buf_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_begin = 1'b0;
    logic        seq_in = 1'b0;
    logic        seq_end = 1'b0;
    logic        seq_rd_en = 1'b0;
    logic        seq_wr_en = 1'b0;
    logic [7:0]  seq_wdata = '0;
    logic [7:0]  seq_rdata;
    logic        seq_busy;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_buf u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_begin(seq_begin),
        .seq_in(seq_in), .seq_end(seq_end), .seq_rd_en(seq_rd_en),
        .seq_wr_en(seq_wr_en), .seq_wdata(seq_wdata), .seq_rdata(seq_rdata),
        .seq_busy(seq_busy)
    );

    localparam logic [1:0] S_CTRL = 2'd0, S_DATA = 2'd1, S_START = 2'd2;
    localparam logic [31:0] DIR_W = 32'h8000_0000, AUTO = 32'h4000_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic put_word(input int addr, input logic [31:0] d);
        reg_write(S_CTRL, DIR_W | 32'(addr));
        reg_write(S_DATA, d);
    endtask

    task automatic get_word(input int addr, output logic [31:0] d);
        reg_write(S_CTRL, 32'(addr));
        reg_read(S_DATA, d);
    endtask

    task automatic seq_go(input logic dir_in);
        @(negedge clk);
        seq_begin = 1'b1; seq_in = dir_in;
        @(negedge clk);
        seq_begin = 1'b0;
    endtask

    task automatic seq_stop();
        @(negedge clk);
        seq_end = 1'b1;
        @(negedge clk);
        seq_end = 1'b0;
    endtask

    task automatic seq_get(output logic [7:0] b);
        @(negedge clk);
        seq_rd_en = 1'b1;
        #1 b = seq_rdata;
        @(negedge clk);
        seq_rd_en = 1'b0;
    endtask

    task automatic seq_put(input logic [7:0] b);
        @(negedge clk);
        seq_wr_en = 1'b1; seq_wdata = b;
        @(negedge clk);
        seq_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(S_CTRL, v);  chk("R1 ctrl after reset", v, 32'h0);
        reg_read(S_START, v); chk("R1 start after reset", v, 32'h0);
        chk("R1 busy after reset", 32'(seq_busy), 32'h0);
        chk("R1 seq_rdata after reset", 32'(seq_rdata), 32'h0);
    endtask

    task automatic t_sw_stream();
        logic [31:0] v;
        reg_write(S_CTRL, DIR_W | AUTO | 32'd5);
        reg_read(S_CTRL, v); chk("R6 ctrl readback", v, 32'hC000_0005);
        reg_write(S_DATA, 32'h1111_AAAA);
        reg_write(S_DATA, 32'h2222_BBBB);
        reg_write(S_DATA, 32'h3333_CCCC);
        reg_read(S_CTRL, v); chk("R2 auto write advance", v, 32'hC000_0008);
        reg_write(S_CTRL, AUTO | 32'd5);
        reg_read(S_DATA, v); chk("R3 read word5", v, 32'h1111_AAAA);
        reg_read(S_DATA, v); chk("R3 read word6", v, 32'h2222_BBBB);
        reg_read(S_DATA, v); chk("R3 read word7", v, 32'h3333_CCCC);
        reg_read(S_CTRL, v); chk("R3 auto read advance", v, 32'h4000_0008);
        reg_write(S_CTRL, DIR_W | 32'd10);
        reg_write(S_DATA, 32'h0BAD_0001);
        reg_write(S_DATA, 32'h600D_0002);
        reg_read(S_CTRL, v); chk("R2 no-auto holds", v, 32'h8000_000A);
        reg_write(S_CTRL, 32'd10);
        reg_read(S_DATA, v); chk("R2 overwrite same word", v, 32'h600D_0002);
        reg_read(S_DATA, v); chk("R3 no-auto reread", v, 32'h600D_0002);
        reg_read(S_CTRL, v); chk("R3 no-auto read holds", v, 32'h0000_000A);
        reg_write(S_CTRL, 32'h85);
        reg_read(S_CTRL, v); chk("R6 address modulo 128", v, 32'h5);
        reg_write(S_START, 32'h1FF);
        reg_read(S_START, v); chk("R6 start modulo 128", v, 32'h7F);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        reg_write(S_CTRL, DIR_W | AUTO | 32'd127);
        reg_write(S_DATA, 32'hFEED_0127);
        reg_write(S_DATA, 32'hFEED_0000);
        reg_read(S_CTRL, v); chk("R4 write wrap addr", v, 32'hC000_0001);
        reg_write(S_CTRL, AUTO | 32'd127);
        reg_read(S_DATA, v); chk("R4 read word127", v, 32'hFEED_0127);
        reg_read(S_DATA, v); chk("R4 read word0 after wrap", v, 32'hFEED_0000);
    endtask

    task automatic t_wrong_dir();
        logic [31:0] v;
        put_word(20, 32'h5A5A_2020);
        reg_write(S_CTRL, AUTO | 32'd20);
        @(negedge clk);
        reg_sel = S_DATA; reg_wdata = 32'hDEAD_BEEF; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_read(S_CTRL, v); chk("R5 write in read dir no advance", v, 32'h4000_0014);
        reg_write(S_CTRL, 32'd20);
        reg_read(S_DATA, v); chk("R5 write in read dir no store", v, 32'h5A5A_2020);
        reg_write(S_CTRL, DIR_W | AUTO | 32'd20);
        reg_read(S_DATA, v); chk("R5 read in write dir gives 0", v, 32'h0);
        reg_read(S_CTRL, v); chk("R5 read in write dir no advance", v, 32'hC000_0014);
    endtask

    task automatic t_seq_out();
        logic [7:0] b;
        logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        put_word(30, 32'h4433_2211);
        put_word(31, 32'h8877_6655);
        reg_write(S_START, 32'd30);
        seq_go(1'b0);
        chk("R7 busy after begin", 32'(seq_busy), 32'h1);
        for (int i = 0; i < 6; i++) begin
            seq_get(b); chk("R8 outgoing byte order", 32'(b), 32'(exp[i]));
        end
        seq_stop();
        chk("R12 idle after end (out)", 32'(seq_busy), 32'h0);
    endtask

    task automatic t_seq_out_wrap();
        logic [7:0] b;
        logic [7:0] exp [6] = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h01, 8'h02};
        put_word(127, 32'hDDCC_BBAA);
        put_word(0, 32'h0403_0201);
        reg_write(S_START, 32'd127);
        seq_go(1'b0);
        for (int i = 0; i < 6; i++) begin
            seq_get(b); chk("R8 byte pointer wrap 511 to 0", 32'(b), 32'(exp[i]));
        end
        seq_stop();
    endtask

    task automatic t_seq_in_full();
        logic [31:0] v;
        reg_write(S_START, 32'd40);
        seq_go(1'b1);
        chk("R7 busy after begin (in)", 32'(seq_busy), 32'h1);
        for (int i = 0; i < 8; i++) seq_put(8'h10 + 8'(i));
        seq_stop();
        chk("R12 idle after end, nothing pending", 32'(seq_busy), 32'h0);
        get_word(40, v); chk("R9 committed word40", v, 32'h1312_1110);
        get_word(41, v); chk("R9 committed word41", v, 32'h1716_1514);
    endtask

    task automatic t_seq_in_partial();
        logic [31:0] v;
        put_word(50, 32'hAAAA_AAAA);
        put_word(51, 32'hBBBB_BBBB);
        reg_write(S_START, 32'd50);
        seq_go(1'b1);
        for (int i = 1; i <= 6; i++) seq_put(8'(i));
        seq_stop();
        chk("R10 busy during flush", 32'(seq_busy), 32'h1);
        @(negedge clk);
        chk("R10 idle after flush", 32'(seq_busy), 32'h0);
        get_word(50, v); chk("R10 full word before partial", v, 32'h0403_0201);
        get_word(51, v); chk("R10 partial lanes only", v, 32'hBBBB_0605);
    endtask

    task automatic t_ctrl_collision();
        logic [31:0] v;
        put_word(60, 32'hCCCC_CCCC);
        put_word(61, 32'hDDDD_DDDD);
        reg_write(S_START, 32'd60);
        seq_go(1'b1);
        seq_put(8'hA0);
        seq_put(8'hA1);
        @(negedge clk);
        reg_sel = S_CTRL; reg_wdata = DIR_W; reg_wr = 1'b1;
        seq_wr_en = 1'b1; seq_wdata = 8'hA2;
        @(negedge clk);
        reg_wr = 1'b0; seq_wr_en = 1'b0;
        seq_put(8'hA3);
        seq_put(8'hB0);
        seq_put(8'hB1);
        seq_stop();
        @(negedge clk);
        get_word(60, v); chk("R11 pending dropped, lane3 only", v, 32'hA3CC_CCCC);
        get_word(61, v); chk("R11 pointer kept advancing", v, 32'hDDDD_B1B0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sw_stream();
        t_wrap();
        t_wrong_dir();
        t_seq_out();
        t_seq_out_wrap();
        t_seq_in_full();
        t_seq_in_partial();
        t_ctrl_collision();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule